// File: doc/BRIEF.md
# 18-bit Instruction Decoder

This block turns one 18-bit instruction word into the fields and control strobes that an execution stage of a small 8-bit core needs. It is purely combinational: the instruction class comes from a leading-ones prefix of one to seven bits, and the meaning of the remaining bits depends on which class matched. From the class and its function code the decoder produces an ALU operation, an immediate-select, register and flag write enables, memory and I/O strobes, branch, jump, call and return indications, and an illegal flag.

The decoder drives an execute stage that holds the register file, the flags and the program counter. Register 0 is treated as a constant zero. Writes that name it as the destination are dropped, so a subtract into r0 acts as a compare. A zero flag on each source field lets the datapath read r0 as zero, which gives zero-base addressing.

Top module: `instr_decoder`

## Requirements
- R1: The class output is set by the number of leading ones in bits 17..11: 0 gives 0 (ALU immediate), 1 gives 1 (memory/I/O), 2 gives 2 (shift), 3 gives 3 (ALU register), 4 gives 4 (jump), 5 gives 5 (branch), 6 gives 6 (misc), and seven ones give 7 with `illegal_o` set and every strobe and write enable low.
- R2: ALU immediate layout: fn at bits 16..14, rd at 13..11, rs at 10..8, immediate at 7..0. The outputs are `alu_op_o` = {0,fn} (0 add, 1 addc, 2 sub, 3 subc, 4 and, 5 or, 6 xor, 7 mask), `use_imm_o` = 1 and `flag_we_o` = 1. Word 0x05D18 decodes as fn 1, rd 3, rs 5, immediate 24.
- R3: Memory/I/O layout: fn at 15..14, then rd, rs and an 8-bit offset in the same places as R2. The outputs are `alu_op_o` = 0 (address add) and `use_imm_o` = 1. fn 0 is a memory load, 1 a memory store, 2 an I/O input and 3 an I/O output, each raising exactly its own strobe. Only fn 0 and fn 2 write a register.
- R4: Shift layout: bit 14 unused, rd at 13..11, rs at 10..8, count at 7..5, fn at 1..0. The outputs are `alu_op_o` = 8+fn (shl, shr, rol, ror) and `imm_o` = the count zero-extended. ALU register layout: rd at 13..11, rs at 10..8, rs2 at 7..5, fn at 2..0, with `alu_op_o` = fn and `use_imm_o` = 0.
- R5: Jump layout: fn at bit 12, address at 11..0. fn 0 raises `jump_o` and fn 1 raises `call_o`, and `jaddr_o` carries the address.
- R6: Branch layout: fn at 11..10, displacement at 7..0. The outputs are `branch_o` = 1, `br_kind_o` = fn (0 zero set, 1 zero clear, 2 carry set, 3 carry clear) and `disp_o` = displacement.
- R7: Misc layout: fn at 10..8, copied to `misc_op_o`. Codes 0..5 raise `misc_o`, and code 0 also raises `ret_o`. Codes 6 and 7 raise `illegal_o` and keep every write enable and strobe low.
- R8: A register-writing instruction whose rd is 0 leaves `reg_we_o` low. Its `flag_we_o` is unchanged.
- R9: `rs_zero_o` is high when a class that carries rs (ALU immediate, memory, shift, ALU register) has rs = 0. `rs2_zero_o` is high for an ALU register instruction with rs2 = 0.
- R10: `flag_we_o` is high only for the ALU immediate, shift and ALU register classes. Any field output that the current class does not carry reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 18 | Instruction word |
| op_class_o | output | 3 | Instruction class code |
| alu_op_o | output | 4 | ALU operation |
| rd_o | output | 3 | Destination register |
| rs_o | output | 3 | First source / base register |
| rs2_o | output | 3 | Second source register |
| imm_o | output | 8 | Immediate, offset or count |
| use_imm_o | output | 1 | Second operand is imm_o |
| disp_o | output | 8 | Branch displacement |
| jaddr_o | output | 12 | Jump/call target |
| br_kind_o | output | 2 | Branch condition |
| misc_op_o | output | 3 | Misc function code |
| reg_we_o | output | 1 | Register write enable |
| flag_we_o | output | 1 | Condition flag write enable |
| mem_rd_o | output | 1 | Data memory read |
| mem_wr_o | output | 1 | Data memory write |
| io_rd_o | output | 1 | I/O read |
| io_wr_o | output | 1 | I/O write |
| branch_o | output | 1 | Conditional branch |
| jump_o | output | 1 | Unconditional jump |
| call_o | output | 1 | Subroutine call |
| ret_o | output | 1 | Subroutine return |
| misc_o | output | 1 | Legal misc instruction |
| illegal_o | output | 1 | Undefined encoding |
| rs_zero_o | output | 1 | rs names r0 |
| rs2_zero_o | output | 1 | rs2 names r0 |

## Verification
The decoder holds no state, so any fault appears at the ports in the same cycle the word is applied. A wrong prefix count shows as a wrong class code, and with it field outputs that are zeroed or copied from the wrong bits. A wrong field slice shows as a shifted register number or immediate. Gating faults show as a write enable or strobe on an illegal word, or a write to r0. The bench applies one word per cycle and compares every output half a cycle later.

// File: rtl/dec_pkg.sv
package dec_pkg;
   typedef enum logic [2:0] {
      CL_ALU_IMM = 3'd0,
      CL_MEM     = 3'd1,
      CL_SHIFT   = 3'd2,
      CL_ALU_REG = 3'd3,
      CL_JUMP    = 3'd4,
      CL_BRANCH  = 3'd5,
      CL_MISC    = 3'd6,
      CL_BAD     = 3'd7
   } op_class_e;

   localparam int PREFIX_MAX = 7;
   localparam logic [3:0] ALU_ADD   = 4'd0;
   localparam logic [1:0] SHIFT_HI  = 2'b10;
   localparam logic [2:0] MISC_LAST = 3'd5;
endpackage

// File: rtl/dec_class_detect.sv
module dec_class_detect #(
   parameter int PW = dec_pkg::PREFIX_MAX
) (
   input  logic [PW-1:0]      pre_i,
   output dec_pkg::op_class_e cls_o
);
   import dec_pkg::*;
   localparam int CW = $clog2(PW + 1);

   logic [PW-1:0] run;
   logic [CW-1:0] n_ones;

   assign run[PW-1] = pre_i[PW-1];
   for (genvar i = PW - 2; i >= 0; i--) begin : g_run
      assign run[i] = run[i+1] & pre_i[i];
   end

   assign n_ones = CW'($countones(run));
   assign cls_o  = op_class_e'(n_ones);

   always_comb begin
      AST_LEAD_ZERO: assert (pre_i[PW-1] || cls_o == CL_ALU_IMM); // R1
      AST_ALL_ONES: assert (!(&pre_i) || cls_o == CL_BAD); // R1
   end
endmodule

// File: rtl/dec_field_extract.sv
module dec_field_extract #(
   parameter int INSTR_W = 18,
   parameter int RA_W    = 3,
   parameter int IMM_W   = 8,
   parameter int JADDR_W = 12
) (
   input  logic [INSTR_W-1:0] instr_i,
   output logic [RA_W-1:0]    rd_o,
   output logic [RA_W-1:0]    rs_o,
   output logic [RA_W-1:0]    rs2_o,
   output logic [IMM_W-1:0]   imm_o,
   output logic [JADDR_W-1:0] jaddr_o,
   output logic [2:0]         fn_imm_o,
   output logic [1:0]         fn_mem_o,
   output logic [1:0]         fn_shift_o,
   output logic [2:0]         fn_reg_o,
   output logic               fn_jmp_o,
   output logic [1:0]         fn_br_o,
   output logic [2:0]         fn_misc_o
);
   localparam int RS_LSB  = IMM_W;
   localparam int RD_LSB  = IMM_W + RA_W;
   localparam int RS2_LSB = IMM_W - RA_W;

   assign rd_o       = instr_i[RD_LSB +: RA_W];
   assign rs_o       = instr_i[RS_LSB +: RA_W];
   assign rs2_o      = instr_i[RS2_LSB +: RA_W];
   assign imm_o      = instr_i[IMM_W-1:0];
   assign jaddr_o    = instr_i[JADDR_W-1:0];
   assign fn_imm_o   = instr_i[INSTR_W-2 -: 3];
   assign fn_mem_o   = instr_i[INSTR_W-3 -: 2];
   assign fn_shift_o = instr_i[1:0];
   assign fn_reg_o   = instr_i[2:0];
   assign fn_jmp_o   = instr_i[INSTR_W-6];
   assign fn_br_o    = instr_i[INSTR_W-7 -: 2];
   assign fn_misc_o  = instr_i[INSTR_W-8 -: 3];
endmodule

// File: rtl/dec_ctrl_gen.sv
module dec_ctrl_gen #(
   parameter int RA_W        = 3,
   parameter int IMM_W       = 8,
   parameter int JADDR_W     = 12,
   parameter bit ZERO_REG_EN = 1'b1
) (
   input  dec_pkg::op_class_e cls_i,
   input  logic [RA_W-1:0]    rd_i,
   input  logic [RA_W-1:0]    rs_i,
   input  logic [RA_W-1:0]    rs2_i,
   input  logic [IMM_W-1:0]   imm_i,
   input  logic [JADDR_W-1:0] jaddr_i,
   input  logic [2:0]         fn_imm_i,
   input  logic [1:0]         fn_mem_i,
   input  logic [1:0]         fn_shift_i,
   input  logic [2:0]         fn_reg_i,
   input  logic               fn_jmp_i,
   input  logic [1:0]         fn_br_i,
   input  logic [2:0]         fn_misc_i,
   output logic [3:0]         alu_op_o,
   output logic [RA_W-1:0]    rd_o,
   output logic [RA_W-1:0]    rs_o,
   output logic [RA_W-1:0]    rs2_o,
   output logic [IMM_W-1:0]   imm_o,
   output logic               use_imm_o,
   output logic [IMM_W-1:0]   disp_o,
   output logic [JADDR_W-1:0] jaddr_o,
   output logic [1:0]         br_kind_o,
   output logic [2:0]         misc_op_o,
   output logic               reg_we_o,
   output logic               flag_we_o,
   output logic               mem_rd_o,
   output logic               mem_wr_o,
   output logic               io_rd_o,
   output logic               io_wr_o,
   output logic               branch_o,
   output logic               jump_o,
   output logic               call_o,
   output logic               ret_o,
   output logic               misc_o,
   output logic               illegal_o,
   output logic               rs_zero_o,
   output logic               rs2_zero_o
);
   import dec_pkg::*;

   logic wr_cand;
   logic uses_rs2;
   logic rd_ok;
   logic rs_z;
   logic rs2_z;

   always_comb begin
      alu_op_o  = '0;
      rd_o      = '0;
      rs_o      = '0;
      rs2_o     = '0;
      imm_o     = '0;
      use_imm_o = 1'b0;
      disp_o    = '0;
      jaddr_o   = '0;
      br_kind_o = '0;
      misc_op_o = '0;
      wr_cand   = 1'b0;
      uses_rs2  = 1'b0;
      flag_we_o = 1'b0;
      mem_rd_o  = 1'b0;
      mem_wr_o  = 1'b0;
      io_rd_o   = 1'b0;
      io_wr_o   = 1'b0;
      branch_o  = 1'b0;
      jump_o    = 1'b0;
      call_o    = 1'b0;
      ret_o     = 1'b0;
      misc_o    = 1'b0;
      illegal_o = 1'b0;
      unique case (cls_i)
         CL_ALU_IMM: begin
            alu_op_o  = {1'b0, fn_imm_i};
            rd_o      = rd_i;
            rs_o      = rs_i;
            imm_o     = imm_i;
            use_imm_o = 1'b1;
            wr_cand   = 1'b1;
            flag_we_o = 1'b1;
         end
         CL_MEM: begin
            alu_op_o  = ALU_ADD;
            rd_o      = rd_i;
            rs_o      = rs_i;
            imm_o     = imm_i;
            use_imm_o = 1'b1;
            unique case (fn_mem_i)
               2'd0: begin mem_rd_o = 1'b1; wr_cand = 1'b1; end
               2'd1: mem_wr_o = 1'b1;
               2'd2: begin io_rd_o = 1'b1; wr_cand = 1'b1; end
               default: io_wr_o = 1'b1;
            endcase
         end
         CL_SHIFT: begin
            alu_op_o  = {SHIFT_HI, fn_shift_i};
            rd_o      = rd_i;
            rs_o      = rs_i;
            imm_o     = {{(IMM_W-RA_W){1'b0}}, rs2_i};
            use_imm_o = 1'b1;
            wr_cand   = 1'b1;
            flag_we_o = 1'b1;
         end
         CL_ALU_REG: begin
            alu_op_o  = {1'b0, fn_reg_i};
            rd_o      = rd_i;
            rs_o      = rs_i;
            rs2_o     = rs2_i;
            uses_rs2  = 1'b1;
            wr_cand   = 1'b1;
            flag_we_o = 1'b1;
         end
         CL_JUMP: begin
            jaddr_o = jaddr_i;
            jump_o  = !fn_jmp_i;
            call_o  = fn_jmp_i;
         end
         CL_BRANCH: begin
            branch_o  = 1'b1;
            br_kind_o = fn_br_i;
            disp_o    = imm_i;
         end
         CL_MISC: begin
            misc_op_o = fn_misc_i;
            if (fn_misc_i <= MISC_LAST) begin
               misc_o = 1'b1;
               ret_o  = (fn_misc_i == 3'd0);
            end else begin
               illegal_o = 1'b1;
            end
         end
         default: illegal_o = 1'b1;
      endcase
   end

   if (ZERO_REG_EN) begin : g_zero_reg
      assign rd_ok = (rd_o != '0);
      assign rs_z  = (cls_i <= CL_ALU_REG) && (rs_o == '0);
      assign rs2_z = uses_rs2 && (rs2_o == '0);
   end else begin : g_plain_reg
      assign rd_ok = 1'b1;
      assign rs_z  = 1'b0;
      assign rs2_z = 1'b0;
   end

   assign reg_we_o   = wr_cand & rd_ok;
   assign rs_zero_o  = rs_z;
   assign rs2_zero_o = rs2_z;

   always_comb begin
      AST_ILLEGAL_QUIET: assert (!illegal_o || !(reg_we_o || flag_we_o || mem_rd_o || mem_wr_o || io_rd_o || io_wr_o)); // R7
      AST_R0_NO_WRITE: assert (!ZERO_REG_EN || rd_i != '0 || !reg_we_o); // R8
      AST_ONE_STROBE: assert ($onehot0({mem_rd_o, mem_wr_o, io_rd_o, io_wr_o})); // R3
      AST_ONE_FLOW: assert ($onehot0({branch_o, jump_o, call_o, ret_o, illegal_o})); // R5
      AST_FLAGS_ALU: assert (!flag_we_o || cls_i == CL_ALU_IMM || cls_i == CL_SHIFT || cls_i == CL_ALU_REG); // R10
   end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder #(
   parameter int INSTR_W     = 18,
   parameter int RA_W        = 3,
   parameter int IMM_W       = 8,
   parameter int JADDR_W     = 12,
   parameter bit ZERO_REG_EN = 1'b1
) (
   input  logic [INSTR_W-1:0] instr_i,
   output logic [2:0]         op_class_o,
   output logic [3:0]         alu_op_o,
   output logic [RA_W-1:0]    rd_o,
   output logic [RA_W-1:0]    rs_o,
   output logic [RA_W-1:0]    rs2_o,
   output logic [IMM_W-1:0]   imm_o,
   output logic               use_imm_o,
   output logic [IMM_W-1:0]   disp_o,
   output logic [JADDR_W-1:0] jaddr_o,
   output logic [1:0]         br_kind_o,
   output logic [2:0]         misc_op_o,
   output logic               reg_we_o,
   output logic               flag_we_o,
   output logic               mem_rd_o,
   output logic               mem_wr_o,
   output logic               io_rd_o,
   output logic               io_wr_o,
   output logic               branch_o,
   output logic               jump_o,
   output logic               call_o,
   output logic               ret_o,
   output logic               misc_o,
   output logic               illegal_o,
   output logic               rs_zero_o,
   output logic               rs2_zero_o
);
   import dec_pkg::*;

   if (INSTR_W != 1 + 3 + 2 * RA_W + IMM_W) begin : g_bad_width
      $error("instr_decoder: INSTR_W does not match the field widths");
   end
   if (JADDR_W != INSTR_W - 6) begin : g_bad_jaddr
      $error("instr_decoder: JADDR_W must leave room for the jump prefix");
   end
   if (IMM_W < RA_W + 3) begin : g_bad_imm
      $error("instr_decoder: IMM_W too small for rs2 and fn fields");
   end

   op_class_e             cls;
   logic [RA_W-1:0]       f_rd, f_rs, f_rs2;
   logic [IMM_W-1:0]      f_imm;
   logic [JADDR_W-1:0]    f_jaddr;
   logic [2:0]            f_fn_imm, f_fn_reg, f_fn_misc;
   logic [1:0]            f_fn_mem, f_fn_shift, f_fn_br;
   logic                  f_fn_jmp;

   dec_class_detect #(.PW(PREFIX_MAX)) u_class (
      .pre_i (instr_i[INSTR_W-1 -: PREFIX_MAX]),
      .cls_o (cls)
   );

   dec_field_extract #(
      .INSTR_W(INSTR_W), .RA_W(RA_W), .IMM_W(IMM_W), .JADDR_W(JADDR_W)
   ) u_fields (
      .instr_i    (instr_i),
      .rd_o       (f_rd),
      .rs_o       (f_rs),
      .rs2_o      (f_rs2),
      .imm_o      (f_imm),
      .jaddr_o    (f_jaddr),
      .fn_imm_o   (f_fn_imm),
      .fn_mem_o   (f_fn_mem),
      .fn_shift_o (f_fn_shift),
      .fn_reg_o   (f_fn_reg),
      .fn_jmp_o   (f_fn_jmp),
      .fn_br_o    (f_fn_br),
      .fn_misc_o  (f_fn_misc)
   );

   dec_ctrl_gen #(
      .RA_W(RA_W), .IMM_W(IMM_W), .JADDR_W(JADDR_W), .ZERO_REG_EN(ZERO_REG_EN)
   ) u_ctrl (
      .cls_i      (cls),
      .rd_i       (f_rd),
      .rs_i       (f_rs),
      .rs2_i      (f_rs2),
      .imm_i      (f_imm),
      .jaddr_i    (f_jaddr),
      .fn_imm_i   (f_fn_imm),
      .fn_mem_i   (f_fn_mem),
      .fn_shift_i (f_fn_shift),
      .fn_reg_i   (f_fn_reg),
      .fn_jmp_i   (f_fn_jmp),
      .fn_br_i    (f_fn_br),
      .fn_misc_i  (f_fn_misc),
      .alu_op_o   (alu_op_o),
      .rd_o       (rd_o),
      .rs_o       (rs_o),
      .rs2_o      (rs2_o),
      .imm_o      (imm_o),
      .use_imm_o  (use_imm_o),
      .disp_o     (disp_o),
      .jaddr_o    (jaddr_o),
      .br_kind_o  (br_kind_o),
      .misc_op_o  (misc_op_o),
      .reg_we_o   (reg_we_o),
      .flag_we_o  (flag_we_o),
      .mem_rd_o   (mem_rd_o),
      .mem_wr_o   (mem_wr_o),
      .io_rd_o    (io_rd_o),
      .io_wr_o    (io_wr_o),
      .branch_o   (branch_o),
      .jump_o     (jump_o),
      .call_o     (call_o),
      .ret_o      (ret_o),
      .misc_o     (misc_o),
      .illegal_o  (illegal_o),
      .rs_zero_o  (rs_zero_o),
      .rs2_zero_o (rs2_zero_o)
   );

   assign op_class_o = cls;
endmodule

// File: tb/instr_decoder_tb.sv
module instr_decoder_tb;
   typedef struct packed {
      logic [2:0]  cls;
      logic [3:0]  alu;
      logic [2:0]  rd;
      logic [2:0]  rs;
      logic [2:0]  rs2;
      logic [7:0]  imm;
      logic        use_imm;
      logic [7:0]  disp;
      logic [11:0] jaddr;
      logic [1:0]  bk;
      logic [2:0]  mop;
      logic        reg_we;
      logic        flag_we;
      logic        mem_rd;
      logic        mem_wr;
      logic        io_rd;
      logic        io_wr;
      logic        br;
      logic        jmp;
      logic        call;
      logic        ret;
      logic        misc;
      logic        ill;
      logic        rsz;
      logic        rs2z;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [17:0] instr = '0;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   exp_t  q_exp[$];
   string q_tag[$];
   exp_t  got;

   always #5 clk = ~clk;

   instr_decoder u_dut (
      .instr_i(instr), .op_class_o(got.cls), .alu_op_o(got.alu),
      .rd_o(got.rd), .rs_o(got.rs), .rs2_o(got.rs2), .imm_o(got.imm),
      .use_imm_o(got.use_imm), .disp_o(got.disp), .jaddr_o(got.jaddr),
      .br_kind_o(got.bk), .misc_op_o(got.mop), .reg_we_o(got.reg_we),
      .flag_we_o(got.flag_we), .mem_rd_o(got.mem_rd), .mem_wr_o(got.mem_wr),
      .io_rd_o(got.io_rd), .io_wr_o(got.io_wr), .branch_o(got.br),
      .jump_o(got.jmp), .call_o(got.call), .ret_o(got.ret), .misc_o(got.misc),
      .illegal_o(got.ill), .rs_zero_o(got.rsz), .rs2_zero_o(got.rs2z)
   );

   // monitor: one word applied per cycle, compared half a cycle later
   always @(negedge clk) begin
      if (q_exp.size() > 0) begin
         exp_t  e;
         string t;
         e = q_exp.pop_front();
         t = q_tag.pop_front();
         total++;
         if (got !== e) begin
            bad++;
            $display("FAIL %s instr=%h got=%h exp=%h", t, instr, got, e);
         end
      end
   end

   task automatic drive(input logic [17:0] ins, input exp_t e, input string tag);
      @(posedge clk);
      #1;
      instr = ins;
      q_exp.push_back(e);
      q_tag.push_back(tag);
   endtask

   task automatic t_imm(input logic [2:0] fn, input logic [2:0] rd, input logic [2:0] rs,
                        input logic [7:0] im, input string tag);
      exp_t e = '0;
      e.cls = 3'd0; e.alu = {1'b0, fn}; e.rd = rd; e.rs = rs; e.imm = im;
      e.use_imm = 1'b1; e.flag_we = 1'b1; e.reg_we = (rd != 0); e.rsz = (rs == 0);
      drive({1'b0, fn, rd, rs, im}, e, tag);
   endtask

   task automatic t_mem(input logic [1:0] fn, input logic [2:0] rd, input logic [2:0] rs,
                        input logic [7:0] off, input string tag);
      exp_t e = '0;
      e.cls = 3'd1; e.rd = rd; e.rs = rs; e.imm = off; e.use_imm = 1'b1;
      e.mem_rd = (fn == 0); e.mem_wr = (fn == 1); e.io_rd = (fn == 2); e.io_wr = (fn == 3);
      e.reg_we = (fn == 0 || fn == 2) && (rd != 0); e.rsz = (rs == 0);
      drive({2'b10, fn, rd, rs, off}, e, tag);
   endtask

   task automatic t_shf(input logic [1:0] fn, input logic [2:0] rd, input logic [2:0] rs,
                        input logic [2:0] cnt, input string tag);
      exp_t e = '0;
      e.cls = 3'd2; e.alu = 4'd8 + {2'b00, fn}; e.rd = rd; e.rs = rs; e.imm = {5'b0, cnt};
      e.use_imm = 1'b1; e.flag_we = 1'b1; e.reg_we = (rd != 0); e.rsz = (rs == 0);
      drive({3'b110, 1'b0, rd, rs, cnt, 3'b000, fn}, e, tag);
   endtask

   task automatic t_reg(input logic [2:0] fn, input logic [2:0] rd, input logic [2:0] rs,
                        input logic [2:0] rs2, input string tag);
      exp_t e = '0;
      e.cls = 3'd3; e.alu = {1'b0, fn}; e.rd = rd; e.rs = rs; e.rs2 = rs2;
      e.flag_we = 1'b1; e.reg_we = (rd != 0); e.rsz = (rs == 0); e.rs2z = (rs2 == 0);
      drive({4'b1110, rd, rs, rs2, 2'b00, fn}, e, tag);
   endtask

   task automatic t_jmp(input logic fn, input logic [11:0] a, input string tag);
      exp_t e = '0;
      e.cls = 3'd4; e.jaddr = a; e.jmp = !fn; e.call = fn;
      drive({5'b11110, fn, a}, e, tag);
   endtask

   task automatic t_br(input logic [1:0] fn, input logic [7:0] d, input string tag);
      exp_t e = '0;
      e.cls = 3'd5; e.br = 1'b1; e.bk = fn; e.disp = d;
      drive({6'b111110, fn, 2'b11, d}, e, tag);
   endtask

   task automatic t_misc(input logic [2:0] fn, input string tag);
      exp_t e = '0;
      e.cls = 3'd6; e.mop = fn;
      if (fn < 3'd6) begin
         e.misc = 1'b1; e.ret = (fn == 0);
      end else begin
         e.ill = 1'b1;
      end
      drive({7'b1111110, fn, 8'hA5}, e, tag);
   endtask

   initial begin
      exp_t e;
      // reset-time state: all-zero word is add r0,r0,0
      t_imm(3'd0, 3'd0, 3'd0, 8'd0, "R2 reset word");
      repeat (2) @(posedge clk);
      rst_n = 1'b1;

      // R2: the worked example word
      e = '0;
      e.cls = 3'd0; e.alu = 4'd1; e.rd = 3'd3; e.rs = 3'd5; e.imm = 8'd24;
      e.use_imm = 1'b1; e.flag_we = 1'b1; e.reg_we = 1'b1;
      drive(18'h05D18, e, "R2 addc example");
      t_imm(3'd6, 3'd7, 3'd2, 8'hFF, "R2 xor imm");
      t_imm(3'd7, 3'd1, 3'd6, 8'h80, "R2 mask imm");
      t_imm(3'd2, 3'd0, 3'd1, 8'd60, "R8 compare into r0");

      // R3
      t_mem(2'd0, 3'd1, 3'd2, 8'd5, "R3 load");
      t_mem(2'd1, 3'd1, 3'd4, 8'hFE, "R3 store");
      t_mem(2'd2, 3'd3, 3'd0, 8'd157, "R9 input zero base");
      t_mem(2'd3, 3'd3, 3'd7, 8'd0, "R3 output");
      t_mem(2'd2, 3'd0, 3'd5, 8'd9, "R8 input to r0");

      // R4
      for (int f = 0; f < 4; f++) t_shf(f[1:0], 3'd4, 3'd1, 3'(f + 3), "R4 shift");
      for (int f = 0; f < 8; f++) t_reg(f[2:0], 3'(f), 3'(7 - f), 3'd5, "R4 reg alu");
      t_reg(3'd0, 3'd2, 3'd3, 3'd0, "R9 rs2 zero");
      t_shf(2'd1, 3'd0, 3'd0, 3'd7, "R10 shift to r0 keeps flags");

      // R5
      t_jmp(1'b0, 12'h00F, "R5 jmp");
      t_jmp(1'b1, 12'hFFF, "R5 jsb");

      // R6
      for (int f = 0; f < 4; f++) t_br(f[1:0], 8'(8'hFC + f), "R6 branch");

      // R7
      for (int f = 0; f < 8; f++) t_misc(f[2:0], "R7 misc");

      // R1: seven leading ones
      e = '0; e.cls = 3'd7; e.ill = 1'b1;
      drive(18'h3FFFF, e, "R1 all ones");
      drive({7'h7F, 11'h155}, e, "R1 bad prefix");

      @(posedge clk);
      wait (q_exp.size() == 0);
      @(posedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule